// File: doc/BRIEF.md
# Palette Entry Color Packer

This block turns one palette write into a packed truecolor word and keeps it in a small table of sixteen entries. A write carries a table index, four 16-bit channel intensities (red, green, blue, alpha), a grayscale flag and a format code. When grayscale is on, red, green and blue are first replaced by one luminance value. Each channel is then narrowed to the width of its field in the chosen pixel layout, using a rounding rule rather than plain truncation. The fields are shifted into place and combined into a 32-bit word, which is stored at the given index.

A write is accepted only when its index lies inside the table and its format code is defined. A rejected write leaves the table untouched and raises an error flag for one cycle. A separate read index returns any stored entry combinationally from the registered table, so software-facing logic or a pixel pipeline can look up the color of a small index directly.

Top module: `palette_packer`

## Requirements
- R1: A strobe whose index is 16 or greater writes no entry, and `err_o` is 1 in the cycle after that strobe.
- R2: `err_o` is 0 in the cycle after an accepted strobe and in the cycle after a cycle with no strobe.
- R3: Format code 3 is undefined; a strobe carrying it writes no entry and sets `err_o` in the next cycle, as for R1.
- R4: A 16-bit channel value v becomes a w-bit field equal to ((v << w) + 32767 − v) >> 16; a field of width 0 is always 0.
- R5: With `gray_en` = 1, red, green and blue are each replaced by (77·R + 151·G + 28·B) >> 8 before narrowing; alpha is not changed.
- R6: Format code 0 stores blue in bits 4:0, green in bits 9:5, red in bits 14:10, a 1-bit alpha in bit 15, and zeros in bits 31:16.
- R7: Format code 1 stores blue in bits 7:0, green in bits 15:8, red in bits 23:16, and zeros in bits 31:24 (alpha has width 0).
- R8: Format code 2 stores the same color layout as R7 plus an 8-bit alpha in bits 31:24.
- R9: An accepted write is visible on `rd_data` after the next rising clock edge; `rd_data` always shows the entry selected by `rd_idx` without a clock of delay.
- R10: Reset clears every table entry to zero and clears `err_o`.
- R11: In a cycle without a strobe, no table entry changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Table index of the write (IDX_W) |
| red_in | input | 16 | Red intensity |
| grn_in | input | 16 | Green intensity |
| blu_in | input | 16 | Blue intensity |
| alp_in | input | 16 | Alpha intensity |
| gray_en | input | 1 | Replace color by luminance before packing |
| fmt_sel | input | 2 | Pixel layout: 0 = 16-bit 1555, 1 = 32-bit no alpha, 2 = 32-bit with alpha, 3 = undefined |
| rd_idx | input | 4 | Table index to read |
| rd_data | output | 32 | Stored entry at `rd_idx` |
| err_o | output | 1 | One-cycle flag for a rejected write |

## Verification
The checker properties assume the read index is driven from stable logic and that `wr_idx`, `fmt_sel` and `gray_en` are never unknown while `wr_en` is high; the layout properties only judge the entry when `rd_idx` points at the index just written. The stimulus holds to this by driving every input on the falling edge, keeping `rd_idx` on the write index during a write, and drawing indices from 0 to 19 and every format code, so both rejection paths and all three layouts occur under random colors alongside directed rounding limits.

// File: rtl/pal_pkg.sv
package pal_pkg;
   typedef enum logic [1:0] {
      FMT_1555 = 2'd0,
      FMT_X888 = 2'd1,
      FMT_8888 = 2'd2,
      FMT_RSVD = 2'd3
   } pal_fmt_e;

   localparam int CH_W    = 16;   // channel intensity width
   localparam int ENT_W   = 32;   // stored entry width
   localparam int FLD_MAX = 8;    // widest packed field
   localparam int NCH     = 4;    // channels: 0 red, 1 green, 2 blue, 3 alpha

   // field widths per channel for each layout
   localparam int W_1555 [NCH] = '{5, 5, 5, 1};
   localparam int W_X888 [NCH] = '{8, 8, 8, 0};
   localparam int W_8888 [NCH] = '{8, 8, 8, 8};
endpackage

// File: rtl/pal_luma.sv
module pal_luma #(
   parameter int CW  = 16,
   parameter int KR  = 77,
   parameter int KG  = 151,
   parameter int KB  = 28,
   parameter int SHR = 8
) (
   input  logic [CW-1:0] r_i,
   input  logic [CW-1:0] g_i,
   input  logic [CW-1:0] b_i,
   output logic [CW-1:0] y_o
);
   localparam int ACC_W = CW + SHR;

   if (KR + KG + KB > (1 << SHR)) begin : g_bad_weights
      $error("pal_luma: weights exceed unity gain");
   end

   logic [ACC_W-1:0] acc;

   always_comb begin
      acc = ACC_W'(r_i) * ACC_W'(KR)
          + ACC_W'(g_i) * ACC_W'(KG)
          + ACC_W'(b_i) * ACC_W'(KB);
      y_o = acc[ACC_W-1:SHR];
   end
endmodule

// File: rtl/pal_narrow.sv
module pal_narrow #(
   parameter int CW = 16,
   parameter int W  = 5,
   parameter int OW = 8
) (
   input  logic [CW-1:0] v_i,
   output logic [OW-1:0] f_o
);
   localparam int SUM_W = CW + OW + 1;
   localparam logic [SUM_W-1:0] HALF = SUM_W'((1 << (CW - 1)) - 1);

   if (W > OW) begin : g_bad_width
      $error("pal_narrow: field wider than output");
   end

   if (W == 0) begin : g_zero
      assign f_o = '0;
   end else begin : g_scale
      logic [SUM_W-1:0] sum;
      always_comb begin
         sum = (SUM_W'(v_i) << W) + HALF - SUM_W'(v_i);
         f_o = OW'(sum >> CW);
      end
   end
endmodule

// File: rtl/pal_table.sv
module pal_table #(
   parameter int DEPTH = 16,
   parameter int DW    = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] widx,
   input  logic [DW-1:0]            wdata,
   input  logic [$clog2(DEPTH)-1:0] ridx,
   output logic [DW-1:0]            rdata
);
   localparam int AW = $clog2(DEPTH);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("pal_table: depth must be a power of two");
   end

   logic [DW-1:0] ent_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent_q[e] <= '0;
         else if (we && (widx == AW'(e)))
            ent_q[e] <= wdata;
      end
   end

   assign rdata = ent_q[ridx];
endmodule

// File: rtl/palette_packer.sv
module palette_packer
   import pal_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int IDX_W = 5,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [15:0]      red_in,
   input  logic [15:0]      grn_in,
   input  logic [15:0]      blu_in,
   input  logic [15:0]      alp_in,
   input  logic             gray_en,
   input  logic [1:0]       fmt_sel,
   input  logic [AW-1:0]    rd_idx,
   output logic [31:0]      rd_data,
   output logic             err_o
);
   if (IDX_W < AW || IDX_W > 31) begin : g_bad_idx
      $error("palette_packer: index width out of range");
   end
   if (AW != $clog2(DEPTH)) begin : g_bad_aw
      $error("palette_packer: AW must follow DEPTH");
   end

   // luminance stage
   logic [CH_W-1:0] luma;
   logic [CH_W-1:0] ch [NCH];

   pal_luma #(.CW(CH_W)) u_luma (
      .r_i (red_in),
      .g_i (grn_in),
      .b_i (blu_in),
      .y_o (luma)
   );

   always_comb begin
      ch[0] = gray_en ? luma : red_in;
      ch[1] = gray_en ? luma : grn_in;
      ch[2] = gray_en ? luma : blu_in;
      ch[3] = alp_in;
   end

   // narrowing units, one set per layout
   logic [FLD_MAX-1:0] f16 [NCH];
   logic [FLD_MAX-1:0] f32 [NCH];
   logic [FLD_MAX-1:0] f32a[NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pal_narrow #(.CW(CH_W), .W(W_1555[c]), .OW(FLD_MAX)) u_n16 (
         .v_i (ch[c]),
         .f_o (f16[c])
      );
      pal_narrow #(.CW(CH_W), .W(W_X888[c]), .OW(FLD_MAX)) u_n32 (
         .v_i (ch[c]),
         .f_o (f32[c])
      );
      pal_narrow #(.CW(CH_W), .W(W_8888[c]), .OW(FLD_MAX)) u_n32a (
         .v_i (ch[c]),
         .f_o (f32a[c])
      );
   end

   // field placement
   logic [ENT_W-1:0] packed_w;
   logic             fmt_ok;

   always_comb begin
      packed_w = '0;
      fmt_ok   = 1'b1;
      case (pal_fmt_e'(fmt_sel))
         FMT_1555: packed_w = {16'h0, f16[3][0], f16[0][4:0], f16[1][4:0], f16[2][4:0]};
         FMT_X888: packed_w = {f32[3], f32[0], f32[1], f32[2]};
         FMT_8888: packed_w = {f32a[3], f32a[0], f32a[1], f32a[2]};
         default:  fmt_ok   = 1'b0;
      endcase
   end

   // accept / reject
   logic idx_ok, accept, err_q;

   assign idx_ok = ({{(32 - IDX_W){1'b0}}, wr_idx} < 32'(DEPTH));
   assign accept = wr_en && idx_ok && fmt_ok;

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= 1'b0;
      else
         err_q <= wr_en && !accept;
   end

   assign err_o = err_q;

   pal_table #(.DEPTH(DEPTH), .DW(ENT_W)) u_tab (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (accept),
      .widx  (wr_idx[AW-1:0]),
      .wdata (packed_w),
      .ridx  (rd_idx),
      .rdata (rd_data)
   );
endmodule

// File: rtl/pal_packer_chk.sv
module pal_packer_chk #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 5,
   parameter int AW    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic             gray_en,
   input logic [1:0]       fmt_sel,
   input logic [AW-1:0]    rd_idx,
   input logic [31:0]      rd_data,
   input logic             err_o
);
   logic idx_in, same_rd, rst_seen_q;

   assign idx_in = ({{(32 - IDX_W){1'b0}}, wr_idx} < 32'(DEPTH));

   always_ff @(posedge clk) rst_seen_q <= !rst_n;

   assert_bad_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !idx_in) |=> err_o);

   assert_bad_format_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fmt_sel == 2'd3) |=> err_o);

   assert_quiet_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || (idx_in && fmt_sel != 2'd3)) |=> !err_o);

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || !idx_in || fmt_sel == 2'd3) |=>
         (rd_idx != $past(rd_idx)) || $stable(rd_data));

   assert_upper_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx_in && fmt_sel == 2'd0) |=>
         (rd_idx != $past(wr_idx[AW-1:0])) || (rd_data[31:16] == 16'h0));

   assert_no_alpha_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx_in && fmt_sel == 2'd1) |=>
         (rd_idx != $past(wr_idx[AW-1:0])) || (rd_data[31:24] == 8'h0));

   assert_gray_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx_in && gray_en && fmt_sel[1] != fmt_sel[0]) |=>
         (rd_idx != $past(wr_idx[AW-1:0])) ||
         ((rd_data[23:16] == rd_data[15:8]) && (rd_data[15:8] == rd_data[7:0])));

   always_ff @(posedge clk) begin
      if (rst_n && rst_seen_q) begin
         assert_reset_clear_R10: assert (rd_data == 32'h0 && !err_o)
            else $error("entry or flag not cleared after reset");
      end
   end

   assign same_rd = 1'b0;
endmodule

bind palette_packer pal_packer_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_idx  (wr_idx),
   .gray_en (gray_en),
   .fmt_sel (fmt_sel),
   .rd_idx  (rd_idx),
   .rd_data (rd_data),
   .err_o   (err_o)
);

// File: tb/palette_packer_tb.sv
module palette_packer_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [4:0]  wr_idx;
   logic [15:0] red_in, grn_in, blu_in, alp_in;
   logic        gray_en;
   logic [1:0]  fmt_sel;
   logic [3:0]  rd_idx;
   logic [31:0] rd_data;
   logic        err_o;

   int checks = 0;
   int fails  = 0;
   logic [31:0] model [16];

   always #10 clk = ~clk;

   palette_packer u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .red_in  (red_in),
      .grn_in  (grn_in),
      .blu_in  (blu_in),
      .alp_in  (alp_in),
      .gray_en (gray_en),
      .fmt_sel (fmt_sel),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .err_o   (err_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int scale(input int v, input int w);
      longint t;
      t = longint'(v) * (longint'(1) << w) + 32767 - v;
      return int'(t / 65536);
   endfunction

   function automatic logic [31:0] expect_word(input int r, input int g, input int b,
                                               input int a, input bit gray, input int fmt);
      int y;
      if (gray) begin
         y = (r * 77 + g * 151 + b * 28) / 256;
         r = y; g = y; b = y;
      end
      case (fmt)
         0: return 32'(scale(b, 5) + scale(g, 5) * 32 + scale(r, 5) * 1024 + scale(a, 1) * 32768);
         1: return 32'(scale(b, 8) + scale(g, 8) * 256 + scale(r, 8) * 65536);
         default: return {8'(scale(a, 8)), 8'(scale(r, 8)), 8'(scale(g, 8)), 8'(scale(b, 8))};
      endcase
   endfunction

   task automatic wr(input int idx, input int r, input int g, input int b, input int a,
                     input bit gray, input int fmt, input string req);
      bit legal;
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'(idx);
      red_in = 16'(r); grn_in = 16'(g); blu_in = 16'(b); alp_in = 16'(a);
      gray_en = gray; fmt_sel = 2'(fmt); rd_idx = 4'(idx);
      @(negedge clk);
      wr_en = 1'b0;
      legal = (idx < 16) && (fmt != 3);
      if (legal) model[idx] = expect_word(r, g, b, a, gray, fmt);
      chk({req, " err"}, {31'h0, err_o}, {31'h0, !legal});
      chk({req, " entry"}, rd_data, model[idx % 16]);
   endtask

   task automatic sweep(input string req);
      for (int i = 0; i < 16; i++) begin
         rd_idx = 4'(i);
         #1;
         chk(req, rd_data, model[i]);
      end
   endtask

   initial begin
      #4000000;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 16; i++) model[i] = 32'h0;
      rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; gray_en = 1'b0; fmt_sel = '0;
      red_in = '0; grn_in = '0; blu_in = '0; alp_in = '0; rd_idx = '0;
      repeat (3) @(negedge clk);
      // put junk in then reset again to confirm clearing
      rst_n = 1'b1;
      wr(3, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 2, "R8 pre-reset");
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model[3] = 32'h0;
      chk("R10 err", {31'h0, err_o}, 32'h0);
      sweep("R10 cleared");

      // R4 rounding limits
      wr(0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 0, "R4 full 1555");
      chk("R4 full 1555 value", rd_data, 32'h0000FFFF);
      wr(1, 0, 0, 0, 16'h8000, 1'b0, 0, "R4 alpha 0x8000");
      chk("R4 alpha rounds down", rd_data, 32'h0);
      wr(2, 0, 0, 0, 16'h8001, 1'b0, 0, "R4 alpha 0x8001");
      chk("R4 alpha rounds up", rd_data, 32'h00008000);
      wr(4, 16'hFFFF, 16'h0080, 16'h0000, 16'hFFFF, 1'b0, 1, "R7 no alpha");
      chk("R7 layout", rd_data, 32'h00FF0000);
      wr(5, 16'h1234, 16'h5678, 16'h9ABC, 16'hFFFF, 1'b0, 2, "R8 alpha");
      // R5 grayscale
      wr(6, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 2, "R5 gray white");
      wr(7, 16'hFFFF, 0, 0, 16'h0000, 1'b1, 1, "R5 gray red");
      // R1 / R3 rejections
      wr(16, 1, 2, 3, 4, 1'b0, 2, "R1 idx16");
      wr(31, 1, 2, 3, 4, 1'b0, 0, "R1 idx31");
      wr(5, 1, 2, 3, 4, 1'b0, 3, "R3 fmt3");
      sweep("R1 R3 table intact");

      // R11: idle cycles with busy inputs
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         wr_idx = 5'($urandom_range(0, 15)); red_in = 16'($urandom);
         fmt_sel = 2'($urandom_range(0, 2));
      end
      @(negedge clk);
      chk("R2 idle err", {31'h0, err_o}, 32'h0);
      sweep("R11 idle hold");

      // random mix, R9 visibility
      for (int n = 0; n < 600; n++) begin
         int idx, fmt;
         string tag;
         idx = $urandom_range(0, 19);
         fmt = $urandom_range(0, 3);
         if (idx >= 16) tag = "R1";
         else if (fmt == 3) tag = "R3";
         else if (fmt == 0) tag = "R6";
         else if (fmt == 1) tag = "R7";
         else tag = "R8";
         wr(idx, $urandom_range(0, 65535), $urandom_range(0, 65535),
            $urandom_range(0, 65535), $urandom_range(0, 65535),
            1'($urandom_range(0, 1)), fmt, {tag, " R9 random"});
         if (n % 100 == 99) sweep("R9 sweep");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule